// File: doc/BRIEF.md
# SDRAM Burst Column Address Sequencer

This block produces the ordered column indices for one SDRAM read or write burst. A caller presents a starting column, a burst length code, a burst type (sequential or interleaved) and a page-size select, and then pulses `start_i`. From the next clock on, the block emits one column per clock on `col_o` with `valid_o` high. It raises `last_o` on the final beat of a bounded burst. Full-page bursts have no final beat: they keep running until `term_i` is asserted.

For lengths 2, 4 and 8 the column bits above the burst offset stay fixed, so every beat stays inside the aligned block. The low bits either count upward with wrap-around or follow the starting offset XOR the beat number. A full-page burst counts through the whole 256- or 512-column row and wraps across it. A full-page request with interleaved type is flagged as an error on `mode_err_o` and is then run in sequential order. The block issues no commands and handles no row, bank or data.

Top module: `burst_col_seq`

## Requirements
- R1: Out of reset, `valid_o`, `last_o` and `mode_err_o` are low.
- R2: A `start_i` pulse sampled at clock edge k makes `valid_o` high after edge k, with `col_o` equal to the starting column. After that, the burst delivers one new column per clock.
- R3: `len_sel_i` codes are 3'b000 for length 1, 3'b001 for 2, 3'b010 for 4 and 3'b011 for 8. Any code with bit 2 set means full page. For lengths 2, 4 and 8, the column bits above bit 0, 1 or 2 hold the starting column's value on every beat.
- R4: With `interleave_i` low, the low offset bits count up by one per beat from the starting offset and wrap to zero within the block (length 8 from offset 5 gives 5,6,7,0,1,2,3,4).
- R5: With `interleave_i` high, beat n carries the starting offset XOR n (length 8 from offset 5 gives 5,4,7,6,1,0,3,2).
- R6: At length 1 the single beat is the starting column itself, whatever the burst type, and `last_o` is high on that beat.
- R7: On a bounded burst, `last_o` is high only on the final beat, and `valid_o` falls on the clock after that beat.
- R8: A full-page burst counts upward through 256 columns (bits 7:0) when `page512_i` is low, or through 512 columns (bits 8:0) when it is high. It wraps across the page, never raises `last_o`, and keeps going while `term_i` is low.
- R9: A full-page request with `interleave_i` high sets `mode_err_o` from the clock after the start until the next start, and the burst runs in sequential order.
- R10: `term_i` sampled high during a burst (without `start_i`) makes `valid_o` low after that same edge.
- R11: A `start_i` during a running burst abandons it, and the new burst's first column appears after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse; loads the settings below |
| start_col_i | input | COL_W | Starting column |
| len_sel_i | input | 3 | Burst length code |
| interleave_i | input | 1 | 1 = interleaved order, 0 = sequential |
| page512_i | input | 1 | Full-page size: 1 = 512 columns, 0 = 256 |
| term_i | input | 1 | Ends the running burst |
| col_o | output | COL_W | Column of the current beat |
| valid_o | output | 1 | Beat present |
| last_o | output | 1 | Final beat of a bounded burst |
| mode_err_o | output | 1 | Full page was requested with interleaved type |

## Verification
Every output is a register. Beat n of a burst started at edge k therefore shows after edge k+n, and `valid_o` falls after edge k+L for a burst of length L. A terminate or restart sampled at edge j takes effect after edge j. The bench drives inputs on falling edges and samples on the following falling edge, so each result is read exactly half a cycle after the rising edge that produced it. It compares each beat's column and flags against a value worked out from the length, offset and type.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  typedef logic [2:0] len_sel_t;
  localparam int unsigned LEN_FULL_BIT = 2;
  localparam len_sel_t LEN_1    = 3'b000;
  localparam len_sel_t LEN_2    = 3'b001;
  localparam len_sel_t LEN_4    = 3'b010;
  localparam len_sel_t LEN_8    = 3'b011;
  localparam len_sel_t LEN_PAGE = 3'b100;
endpackage

// File: rtl/burst_mask_dec.sv
module burst_mask_dec
  import burst_seq_pkg::*;
#(
  parameter int COL_W  = 9,
  parameter int PAGE_W = 8
) (
  input  len_sel_t         len_sel_i,
  input  logic             page512_i,
  output logic [COL_W-1:0] blk_mask_o,
  output logic             full_o
);
  logic is_full;
  assign is_full = len_sel_i[LEN_FULL_BIT];
  assign full_o  = is_full;

  // one mask bit per column bit: set where the burst offset may move
  for (genvar b = 0; b < COL_W; b++) begin : g_mask
    logic in_page;
    logic in_blk;
    assign in_page = (b < PAGE_W) || (page512_i && (b == PAGE_W));
    assign in_blk  = (b < int'(len_sel_i[1:0]));
    assign blk_mask_o[b] = is_full ? in_page : in_blk;
  end
endmodule

// File: rtl/burst_col_calc.sv
module burst_col_calc #(
  parameter int COL_W = 9
) (
  input  logic [COL_W-1:0] base_i,
  input  logic [COL_W-1:0] beat_i,
  input  logic [COL_W-1:0] mask_i,
  input  logic             ilv_i,
  output logic [COL_W-1:0] col_o
);
  logic [COL_W-1:0] off_seq;
  logic [COL_W-1:0] off_ilv;
  logic [COL_W-1:0] off_sel;

  always_comb begin
    off_seq = base_i + beat_i;
    off_ilv = base_i ^ beat_i;
    off_sel = ilv_i ? off_ilv : off_seq;
    col_o   = (base_i & ~mask_i) | (off_sel & mask_i);
  end
endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
  import burst_seq_pkg::*;
#(
  parameter int COL_W  = 9,
  parameter int PAGE_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [COL_W-1:0] start_col_i,
  input  logic [2:0]       len_sel_i,
  input  logic             interleave_i,
  input  logic             page512_i,
  input  logic             term_i,
  output logic [COL_W-1:0] col_o,
  output logic             valid_o,
  output logic             last_o,
  output logic             mode_err_o
);
  localparam int CNT_W = COL_W;

  // registered state
  logic             valid_q, last_q, err_q, ilv_q, full_q;
  logic [COL_W-1:0] col_q, base_q, mask_q;
  logic [CNT_W-1:0] cnt_q;

  // next state
  logic             valid_n, last_n, err_n, ilv_n, full_n;
  logic [COL_W-1:0] col_n, base_n, mask_n;
  logic [CNT_W-1:0] cnt_n;
  logic             upd_en;

  // decoded settings and the column for the selected beat
  logic [COL_W-1:0] dec_mask;
  logic             dec_full;
  logic [COL_W-1:0] sel_base, sel_mask;
  logic [CNT_W-1:0] sel_cnt;
  logic             sel_ilv;
  logic [COL_W-1:0] calc_col;

  burst_mask_dec #(.COL_W(COL_W), .PAGE_W(PAGE_W)) u_dec (
    .len_sel_i  (len_sel_i),
    .page512_i  (page512_i),
    .blk_mask_o (dec_mask),
    .full_o     (dec_full)
  );

  always_comb begin
    sel_base = start_i ? start_col_i : base_q;
    sel_mask = start_i ? dec_mask : mask_q;
    sel_ilv  = start_i ? (interleave_i & ~dec_full) : ilv_q;
    sel_cnt  = start_i ? '0 : cnt_q + 1'b1;
  end

  burst_col_calc #(.COL_W(COL_W)) u_calc (
    .base_i (sel_base),
    .beat_i (sel_cnt),
    .mask_i (sel_mask),
    .ilv_i  (sel_ilv),
    .col_o  (calc_col)
  );

  assign upd_en = start_i | valid_q;

  always_comb begin
    valid_n = valid_q;
    last_n  = last_q;
    err_n   = err_q;
    ilv_n   = ilv_q;
    full_n  = full_q;
    col_n   = col_q;
    base_n  = base_q;
    mask_n  = mask_q;
    cnt_n   = cnt_q;
    if (start_i) begin
      valid_n = 1'b1;
      base_n  = start_col_i;
      mask_n  = dec_mask;
      full_n  = dec_full;
      ilv_n   = interleave_i & ~dec_full;
      err_n   = interleave_i & dec_full;
      cnt_n   = '0;
      col_n   = calc_col;
      last_n  = ~dec_full & (dec_mask == '0);
    end else if (valid_q) begin
      if (term_i || last_q) begin
        valid_n = 1'b0;
        last_n  = 1'b0;
      end else begin
        cnt_n  = sel_cnt;
        col_n  = calc_col;
        last_n = ~full_q & (sel_cnt == mask_q);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      last_q  <= 1'b0;
      err_q   <= 1'b0;
      ilv_q   <= 1'b0;
      full_q  <= 1'b0;
      col_q   <= '0;
      base_q  <= '0;
      mask_q  <= '0;
      cnt_q   <= '0;
    end else if (upd_en) begin
      valid_q <= valid_n;
      last_q  <= last_n;
      err_q   <= err_n;
      ilv_q   <= ilv_n;
      full_q  <= full_n;
      col_q   <= col_n;
      base_q  <= base_n;
      mask_q  <= mask_n;
      cnt_q   <= cnt_n;
    end
  end

  assign col_o      = col_q;
  assign valid_o    = valid_q;
  assign last_o     = last_q;
  assign mode_err_o = err_q;

  AST_START_GIVES_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> valid_o); // R2
  AST_BLOCK_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && $past(valid_q) && !$past(start_i)) |->
      ((col_q & ~mask_q) == $past(col_q & ~mask_q))); // R3
  AST_LAST_ONLY_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    last_o |-> valid_o); // R7
  AST_LAST_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && last_o && !start_i) |=> !valid_o); // R7
  AST_PAGE_NO_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && full_q) |-> !last_o); // R8
  AST_TERM_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && term_i && !start_i) |=> !valid_o); // R10
endmodule

// File: tb/burst_col_seq_tb.sv
module burst_col_seq_tb;
  localparam int COL_W = 9;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             start_i;
  logic [COL_W-1:0] start_col_i;
  logic [2:0]       len_sel_i;
  logic             interleave_i;
  logic             page512_i;
  logic             term_i;
  logic [COL_W-1:0] col_o;
  logic             valid_o, last_o, mode_err_o;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  burst_col_seq #(.COL_W(COL_W), .PAGE_W(8)) u_dut (
    .clk, .rst_n, .start_i, .start_col_i, .len_sel_i, .interleave_i,
    .page512_i, .term_i, .col_o, .valid_o, .last_o, .mode_err_o
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_col(int base, int lsel, bit ilv, bit p512, int n);
    int len, off, psz;
    if (lsel >= 4) begin
      psz = p512 ? 512 : 256;
      return (base - (base % psz)) + ((base % psz + n) % psz);
    end
    len = 1 << lsel;
    off = base % len;
    if (ilv) return (base - off) + (off ^ n);
    return (base - off) + ((off + n) % len);
  endfunction

  // pulse start on a falling edge; returns at the falling edge showing beat 0
  task automatic kick(int base, int lsel, bit ilv, bit p512);
    start_i      = 1'b1;
    start_col_i  = COL_W'(base);
    len_sel_i    = 3'(lsel);
    interleave_i = ilv;
    page512_i    = p512;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic run_beats(string req, int base, int lsel, bit ilv, bit p512, int nb);
    for (int n = 0; n < nb; n++) begin
      check({req, " col"}, int'(col_o), exp_col(base, lsel, ilv, p512, n));
      check({req, " valid"}, int'(valid_o), 1);
      check({req, " last"}, int'(last_o), (lsel < 4 && n == (1 << lsel) - 1) ? 1 : 0);
      @(negedge clk);
    end
  endtask

  task automatic t_reset;
    check("R1 valid", int'(valid_o), 0);
    check("R1 last", int'(last_o), 0);
    check("R1 err", int'(mode_err_o), 0);
  endtask

  task automatic t_bounded(string req, int base, int lsel, bit ilv);
    kick(base, lsel, ilv, 1'b0);
    run_beats(req, base, lsel, ilv, 1'b0, 1 << lsel);
    check({req, " R7 valid drops"}, int'(valid_o), 0);
  endtask

  task automatic t_page(string req, int base, bit p512, bit ilv, int nb);
    kick(base, 4, ilv, p512);
    run_beats(req, base, 4, ilv, p512, nb);
    check({req, " still running"}, int'(valid_o), 1);
    check({req, " R9 err"}, int'(mode_err_o), ilv ? 1 : 0);
    term_i = 1'b1;
    @(negedge clk);
    term_i = 1'b0;
    check({req, " R10 term"}, int'(valid_o), 0);
  endtask

  task automatic t_term_bounded;
    kick(8'h40, 3, 1'b0, 1'b0);
    run_beats("R10 early", 8'h40, 3, 1'b0, 1'b0, 3);
    term_i = 1'b1;
    @(negedge clk);
    term_i = 1'b0;
    check("R10 valid after term", int'(valid_o), 0);
    check("R10 last after term", int'(last_o), 0);
  endtask

  task automatic t_restart;
    kick(9'h1F0, 3, 1'b1, 1'b0);
    run_beats("R11 first", 9'h1F0, 3, 1'b1, 1'b0, 3);
    kick(9'h0A6, 2, 1'b0, 1'b0);
    run_beats("R11 second", 9'h0A6, 2, 1'b0, 1'b0, 4);
    check("R11 end", int'(valid_o), 0);
  endtask

  task automatic t_err_clear;
    kick(9'h033, 1, 1'b0, 1'b0);
    check("R9 err cleared", int'(mode_err_o), 0);
    run_beats("R9 after", 9'h033, 1, 1'b0, 1'b0, 2);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; start_i = 1'b0; start_col_i = '0; len_sel_i = '0;
    interleave_i = 1'b0; page512_i = 1'b0; term_i = 1'b0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_bounded("R4 seq8", 9'h0AD, 3, 1'b0);    // 5,6,7,0.. in block 0xA8; R2 R3
    t_bounded("R5 ilv8", 9'h0AD, 3, 1'b1);    // 5,4,7,6,1,0,3,2
    t_bounded("R4 seq4", 9'h117, 2, 1'b0);
    t_bounded("R5 ilv4", 9'h117, 2, 1'b1);
    t_bounded("R4 seq2", 9'h0C1, 1, 1'b0);
    t_bounded("R5 ilv2", 9'h0C1, 1, 1'b1);
    t_bounded("R6 len1", 9'h15B, 0, 1'b1);
    t_bounded("R6 len1 seq", 9'h15B, 0, 1'b0);
    t_page("R8 page256", 9'h1FA, 1'b0, 1'b0, 12);
    t_page("R8 page512", 9'h1FC, 1'b1, 1'b0, 10);
    t_page("R9 page ilv", 9'h0FD, 1'b0, 1'b1, 8);
    t_err_clear();
    t_term_bounded();
    t_restart();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule